// File: doc/BRIEF.md
# Per-Port Error Status Interrupt Aggregator

This block gathers single-cycle event pulses from a set of audio ports and holds them in five error groups: playback FIFO underflow (group 0), ring buffer underflow (group 1), ring buffer overflow (group 2), free-mark crossing (group 3) and full-mark crossing (group 4). Inside a group, the bit index is the port number. Playback groups (0, 1, 3) serve four output ports, and bit 3 is the serial digital audio output. Capture groups (2, 4) serve three input ports.

Status bits latch whatever their mask says. A mask only decides whether a latched bit reaches the second level. The second level holds one sticky bit per group. It has its own mask and its own write-one-to-clear. The single interrupt line is the OR of the second-level bits that are not masked.

Software uses a simple word-addressed register port. Masks change only through separate set and clear strobes, so each change needs no read-modify-write.

Top module: `err_irq_agg`

## Requirements
- R1: After reset every group status reads 0, every group mask reads 0xF, the top status reads 0, the top mask reads 0x1F and `irq_o` is 0.
- R2: An event on `evt_i[g*4+p]` sets bit p of group g status at the next clock edge, even while that bit is masked.
- R3: A write to a group clear register clears each status bit whose write-data bit is 1. Bits written 0 are unchanged.
- R4: A write to a group mask-set register sets the mask bits written 1. A write to a group mask-clear register clears the mask bits written 1. Bits written 0 are unchanged.
- R5: In capture groups 2 and 4, bit 3 has no port. Events on it are ignored, its status reads 0 and its mask always reads 1.
- R6: Top status bit g becomes set at the clock edge after group g holds a status bit whose mask bit is clear. Masked status never sets it.
- R7: The top-level clear, mask-set and mask-clear registers act on the top status and top mask bit by bit, with write-1 semantics.
- R8: `irq_o` is 1 exactly when some top status bit is set while its top mask bit is clear.
- R9: An event, or a pending group, in the same cycle as a clear write to the same bit wins: the bit stays set.
- R10: The word address is group*8 + register, with these register numbers: 0 status, 1 clear, 2 mask, 3 mask-set, 4 mask-clear. The top level uses block 5, at addresses 40 to 44. Reads of write-only or unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 20 | Event pulses, group g port p at bit g*4+p |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 5 | Write data |
| rdata_o | output | 5 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle:
- an event latches into its group;
- clears remove a bit only when no event races them;
- mask strobes take effect;
- a pending group reaches the top status one edge later;
- a fully masked top level keeps the interrupt low.

Other behaviours need the bench's scenarios:
- the address map;
- the read-as-zero locations;
- the capture-group bit 3 holes seen through reads;
- the two-edge latency from event to interrupt;
- the ordering of unmasking, clearing and re-raising.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int NUM_GRP    = 5;
  localparam int PORT_W     = 4;
  localparam int PLAY_PORTS = 4;
  localparam int CAP_PORTS  = 3;
  localparam int SUB_W      = 3;
  localparam int ADDR_W     = 6;

  typedef enum logic [SUB_W-1:0] {
    REG_STAT = 3'd0,
    REG_CLR  = 3'd1,
    REG_MASK = 3'd2,
    REG_MSET = 3'd3,
    REG_MCLR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/err_bus_dec.sv
module err_bus_dec
  import err_irq_pkg::*;
#(
  parameter int NUM_G  = NUM_GRP,
  parameter int PW     = PORT_W,
  parameter int AW     = ADDR_W,
  parameter int REG_W  = (PW > NUM_G) ? PW : NUM_G
) (
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [NUM_G*PW-1:0]   grp_stat_i,
  input  logic [NUM_G*PW-1:0]   grp_mask_i,
  input  logic [NUM_G-1:0]      top_stat_i,
  input  logic [NUM_G-1:0]      top_mask_i,
  output logic [NUM_G-1:0]      grp_clr_we_o,
  output logic [NUM_G-1:0]      grp_mset_we_o,
  output logic [NUM_G-1:0]      grp_mclr_we_o,
  output logic                  top_clr_we_o,
  output logic                  top_mset_we_o,
  output logic                  top_mclr_we_o,
  output logic [REG_W-1:0]      rdata_o
);
  localparam int BLK_W = AW - SUB_W;

  logic [BLK_W-1:0] blk;
  logic [SUB_W-1:0] sub;

  assign blk = addr_i[AW-1:SUB_W];
  assign sub = addr_i[SUB_W-1:0];

  for (genvar g = 0; g < NUM_G; g++) begin : g_dec
    logic hit;
    assign hit              = we_i && (blk == BLK_W'(g));
    assign grp_clr_we_o[g]  = hit && (sub == REG_CLR);
    assign grp_mset_we_o[g] = hit && (sub == REG_MSET);
    assign grp_mclr_we_o[g] = hit && (sub == REG_MCLR);
  end

  logic top_hit;
  assign top_hit       = we_i && (blk == BLK_W'(NUM_G));
  assign top_clr_we_o  = top_hit && (sub == REG_CLR);
  assign top_mset_we_o = top_hit && (sub == REG_MSET);
  assign top_mclr_we_o = top_hit && (sub == REG_MCLR);

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_G; g++) begin
      if (blk == BLK_W'(g)) begin
        if (sub == REG_STAT) rdata_o[PW-1:0] = grp_stat_i[g*PW +: PW];
        if (sub == REG_MASK) rdata_o[PW-1:0] = grp_mask_i[g*PW +: PW];
      end
    end
    if (blk == BLK_W'(NUM_G)) begin
      if (sub == REG_STAT) rdata_o[NUM_G-1:0] = top_stat_i;
      if (sub == REG_MASK) rdata_o[NUM_G-1:0] = top_mask_i;
    end
  end
endmodule

// File: rtl/err_grp_reg.sv
module err_grp_reg #(
  parameter int PW    = 4,
  parameter int NPORT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] evt_i,
  input  logic          clr_we_i,
  input  logic          mset_we_i,
  input  logic          mclr_we_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] stat_o,
  output logic [PW-1:0] mask_o,
  output logic          pend_o
);
  localparam logic [PW-1:0] VALID = PW'((1 << NPORT) - 1);

  logic [PW-1:0] stat_q, mask_q, stat_d, mask_d;
  logic [PW-1:0] clr_bits, set_bits, unm_bits;

  assign clr_bits = clr_we_i  ? wdata_i : '0;
  assign set_bits = mset_we_i ? wdata_i : '0;
  assign unm_bits = mclr_we_i ? wdata_i : '0;

  // events override a simultaneous clear
  assign stat_d = ((stat_q & ~clr_bits) | evt_i) & VALID;
  assign mask_d = ((mask_q | set_bits) & ~unm_bits) | ~VALID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

  for (genvar b = 0; b < PW; b++) begin : g_chk
    if (b < NPORT) begin : g_live
      AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[b] |=> stat_o[b]);  // R2
      AST_CLR_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_we_i && wdata_i[b] && !evt_i[b] |=> !stat_o[b]);  // R3
      AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_o[b] && !(clr_we_i && wdata_i[b]) |=> stat_o[b]);  // R9
      AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mset_we_i && wdata_i[b] |=> mask_o[b]);  // R4
      AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclr_we_i && wdata_i[b] |=> !mask_o[b]);  // R4
    end else begin : g_hole
      AST_HOLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[b] |=> !stat_o[b] && mask_o[b]);  // R5
    end
  end
endmodule

// File: rtl/err_top_reg.sv
module err_top_reg #(
  parameter int NUM_G = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_G-1:0] pend_i,
  input  logic             clr_we_i,
  input  logic             mset_we_i,
  input  logic             mclr_we_i,
  input  logic [NUM_G-1:0] wdata_i,
  output logic [NUM_G-1:0] stat_o,
  output logic [NUM_G-1:0] mask_o,
  output logic             irq_o
);
  logic [NUM_G-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~(clr_we_i ? wdata_i : '0)) | pend_i;
      mask_q <= (mask_q | (mset_we_i ? wdata_i : '0)) & ~(mclr_we_i ? wdata_i : '0);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

  for (genvar g = 0; g < NUM_G; g++) begin : g_chk
    AST_PEND_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[g] |=> stat_o[g]);  // R6
    AST_TOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i && wdata_i[g] && !pend_i[g] |=> !stat_o[g]);  // R7
  end

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_o) |-> !irq_o);  // R8
  AST_IRQ_NO_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == '0) |-> !irq_o);  // R8
endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg
  import err_irq_pkg::*;
#(
  parameter int               NUM_G        = NUM_GRP,
  parameter int               PW           = PORT_W,
  parameter int               PLAY_N       = PLAY_PORTS,
  parameter int               CAP_N        = CAP_PORTS,
  parameter logic [NUM_G-1:0] CAP_GRP_MASK = 5'b10100,
  parameter int               AW           = ADDR_W,
  parameter int               REG_W        = (PW > NUM_G) ? PW : NUM_G
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_G*PW-1:0] evt_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic                irq_o
);
  logic [NUM_G*PW-1:0] grp_stat, grp_mask;
  logic [NUM_G-1:0]    grp_pend, clr_we, mset_we, mclr_we;
  logic [NUM_G-1:0]    top_stat, top_mask;
  logic                top_clr_we, top_mset_we, top_mclr_we;

  err_bus_dec #(.NUM_G(NUM_G), .PW(PW), .AW(AW), .REG_W(REG_W)) u_dec (
    .we_i          (wr_en_i),
    .addr_i        (addr_i),
    .grp_stat_i    (grp_stat),
    .grp_mask_i    (grp_mask),
    .top_stat_i    (top_stat),
    .top_mask_i    (top_mask),
    .grp_clr_we_o  (clr_we),
    .grp_mset_we_o (mset_we),
    .grp_mclr_we_o (mclr_we),
    .top_clr_we_o  (top_clr_we),
    .top_mset_we_o (top_mset_we),
    .top_mclr_we_o (top_mclr_we),
    .rdata_o       (rdata_o)
  );

  for (genvar g = 0; g < NUM_G; g++) begin : g_grp
    localparam int NP = CAP_GRP_MASK[g] ? CAP_N : PLAY_N;
    err_grp_reg #(.PW(PW), .NPORT(NP)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[g*PW +: PW]),
      .clr_we_i  (clr_we[g]),
      .mset_we_i (mset_we[g]),
      .mclr_we_i (mclr_we[g]),
      .wdata_i   (wdata_i[PW-1:0]),
      .stat_o    (grp_stat[g*PW +: PW]),
      .mask_o    (grp_mask[g*PW +: PW]),
      .pend_o    (grp_pend[g])
    );
  end

  err_top_reg #(.NUM_G(NUM_G)) u_top (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (grp_pend),
    .clr_we_i  (top_clr_we),
    .mset_we_i (top_mset_we),
    .mclr_we_i (top_mclr_we),
    .wdata_i   (wdata_i[NUM_G-1:0]),
    .stat_o    (top_stat),
    .mask_o    (top_mask),
    .irq_o     (irq_o)
  );

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_we, mset_we, mclr_we, top_clr_we, top_mset_we, top_mclr_we}));  // R10
  AST_WRITE_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> $countones({clr_we, mset_we, mclr_we, top_clr_we, top_mset_we, top_mclr_we}) == 0);  // R10
endmodule

// File: tb/err_irq_agg_bench.sv
module err_irq_agg_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] evt = '0;
  logic        we = 0;
  logic [5:0]  addr = '0;
  logic [4:0]  wdata = '0;
  logic [4:0]  rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [4:0]  rv;

  always #5 clk = ~clk;

  err_irq_agg u_err_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {event pattern, cumulative expected status {g4,g3,g2,g1,g0}}
  localparam logic [39:0] VEC [4] = '{
    40'h00001_00001,
    40'h00A00_00201,
    40'h48000_48201,
    40'h000F0_482F1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [4:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [4:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic pulse(input logic [19:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int g = 0; g < 5; g++) begin
      rd(6'(g*8), rv);     chk("R1 grp status", rv, 0);
      rd(6'(g*8 + 2), rv); chk("R1 grp mask", rv, 5'h0F);
    end
    rd(40, rv); chk("R1 top status", rv, 0);
    rd(42, rv); chk("R1 top mask", rv, 5'h1F);
    chk("R1 irq", irq, 0);

    // R2 / R5 table: events latch while masked
    for (int i = 0; i < 4; i++) begin
      pulse(VEC[i][39:20]);
      for (int g = 0; g < 5; g++) begin
        rd(6'(g*8), rv);
        chk("R2 R5 table status", rv, {1'b0, VEC[i][g*4 +: 4]});
      end
      rd(40, rv); chk("R6 masked no top", rv, 0);
      chk("R8 irq idle", irq, 0);
    end

    // R3 clear
    wr(1, 5'h01); rd(0, rv); chk("R3 clear g0", rv, 0);
    wr(9, 5'h00); rd(8, rv); chk("R3 zero write keeps", rv, 5'h0F);
    wr(9, 5'h03); rd(8, rv); chk("R3 partial clear", rv, 5'h0C);

    // R4 unmask g1 bit 2
    wr(12, 5'h04); rd(10, rv); chk("R4 mask clear", rv, 5'h0B);
    @(negedge clk);
    rd(40, rv); chk("R6 top raise", rv, 5'h02);
    chk("R8 top masked", irq, 0);
    wr(44, 5'h02); rd(42, rv); chk("R7 top mask clear", rv, 5'h1D);
    chk("R8 irq asserted", irq, 1);

    // R9 top clear while still pending
    wr(41, 5'h02); rd(40, rv); chk("R9 top pending wins", rv, 5'h02);
    wr(9, 5'h04); rd(8, rv); chk("R3 clear pending bit", rv, 5'h08);
    wr(41, 5'h02); rd(40, rv); chk("R7 top clear", rv, 0);
    chk("R8 irq drops", irq, 0);
    wr(11, 5'h04); rd(10, rv); chk("R4 mask set", rv, 5'h0F);
    wr(43, 5'h02); rd(42, rv); chk("R7 top mask set", rv, 5'h1F);

    // R9 event vs clear same cycle
    pulse(20'h00001);
    @(negedge clk);
    evt = 20'h00001; we = 1; addr = 1; wdata = 5'h01;
    @(negedge clk);
    evt = '0; we = 0; wdata = '0;
    rd(0, rv); chk("R9 event wins", rv, 5'h01);
    wr(1, 5'h01); rd(0, rv); chk("R3 clear after race", rv, 0);

    // R5 capture hole cannot be unmasked
    wr(20, 5'h0F); rd(18, rv); chk("R5 hole mask", rv, 5'h08);
    pulse(20'h00800); rd(16, rv); chk("R5 hole event", rv, 5'h02);
    @(negedge clk);
    rd(40, rv); chk("R6 g2 raise", rv, 5'h04);

    // R10 read-as-zero
    rd(1, rv);  chk("R10 clear reads 0", rv, 0);
    rd(43, rv); chk("R10 top mset reads 0", rv, 0);
    rd(45, rv); chk("R10 unmapped", rv, 0);
    rd(63, rv); chk("R10 unmapped high", rv, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule